// File: doc/BRIEF.md
# Core Power-Down Sequencer

This block walks a processor core and its private second-level cache from normal running to a state where the supply can be removed safely. The core starts the walk by raising a cache-flush request. The sequencer then waits for flush completion and for the core to halt in wait-for-interrupt. After that it waits for the interconnect coherency handshake to fall quiet on both sides. When all of these hold, it tells the system that the core is idle and ready to be powered off. It stays in that phase until the software reset removes it.

Every handshake input from the core and the interconnect is asynchronous to the block clock, so each one passes through a synchronizer chain before the state machine uses it. The block's own reset combines the system reset with an active-low software reset from the system controller, and that reset is released through a reset synchronizer. There is also a clock-gate request. It is raised for the cycles in which the software reset is asserted while the ready-for-power-off phase is still in effect. A low-power Q-channel pair can only delay the final step. It never changes the order of the phases.

Top module: `core_pwrdn_seq`

## Requirements
- R1: After the system reset is released, `off_ready` and `pd_clk_gate` are both 0, and the sequencer rests in its idle phase.
- R2: The sequence leaves the idle phase only after a synchronized `flush_req` is seen. A single-cycle pulse on `flush_req` is enough to start it.
- R3: In the flush phase the sequencer waits for a synchronized `flush_done`. A `wfi_halt` or quiet coherency pair that arrives earlier does not let it skip this phase.
- R4: In the wait-for-interrupt phase the sequencer waits for a synchronized `wfi_halt`.
- R5: The coherency-exit condition is true only when `coh_req` and `coh_ack` are both 0. The coherency-exit phase moves on only after this condition has been synchronized.
- R6: `off_ready` is 1 exactly while the sequencer is in its ready-for-power-off phase. Once entered, that phase is left only through the block reset.
- R7: `flush_req`, `flush_done`, `wfi_halt` and the coherency-exit condition each pass through SYNC_STAGES flops that reset to 0. With all later conditions already true, `off_ready` rises on the (SYNC_STAGES+4)-th rising edge after `flush_req` is raised.
- R8: The block reset is asserted when `rst_n` is low (asynchronously) or when `sw_rst_n` is low. For `sw_rst_n`, both assertion and release take effect on the RST_STAGES-th rising edge after the change. While the block reset is asserted the sequencer is forced to its idle phase.
- R9: `pd_clk_gate` is a register that loads (`sw_rst_n` low) AND (ready-for-power-off phase) on each edge. It is cleared only by the system reset.
- R10: While the sequencer is in the coherency-exit phase and `q_active` is 1 with `q_accept_n` 1, it holds there. The Q-channel pair has no effect in any other phase, and with either input at 0 it has no effect at all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | System reset, active low, asynchronous assertion |
| sw_rst_n | input | 1 | Software reset from the system controller, active low |
| flush_req | input | 1 | Cache-flush request from the core (asynchronous) |
| flush_done | input | 1 | Cache flush completed (asynchronous) |
| wfi_halt | input | 1 | Core halted in wait-for-interrupt (asynchronous) |
| coh_req | input | 1 | Coherency request level toward the interconnect (asynchronous) |
| coh_ack | input | 1 | Coherency acknowledge from the interconnect (asynchronous) |
| q_active | input | 1 | Q-channel activity indication, synchronous, 0 when unused |
| q_accept_n | input | 1 | Q-channel accept, active low, synchronous, 0 when unused |
| off_ready | output | 1 | Core is idle and ready for power removal |
| pd_clk_gate | output | 1 | Power-down clock-gate request |

## Verification
The bench builds the block with its default parameters: three synchronizer flops per handshake input and a two-stage reset synchronizer. With these, the latency from each handshake to the next phase is short enough that every phase, both exit paths of the coherency phase and the software-reset pulse on the gate flag can be placed at exact edges. The reference model shifts every input through its own synchronizer queues. It is therefore sensitive to a wrong stage count on any individual input, to an early or late release of the software reset, and to a gate flag that is sampled one edge off.

// File: rtl/cpd_pkg.sv
package cpd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_FLUSH  = 3'd1,
    PH_WFI    = 3'd2,
    PH_COHX   = 3'd3,
    PH_OFFREQ = 3'd4
  } cpd_phase_e;

  localparam int unsigned CPD_NUM_HS = 4;
  localparam int unsigned CPD_HS_FLUSH = 0;
  localparam int unsigned CPD_HS_DONE  = 1;
  localparam int unsigned CPD_HS_WFI   = 2;
  localparam int unsigned CPD_HS_COHX  = 3;

endpackage

// File: rtl/cpd_sync.sv
// Multi-bit bank of independent level synchronizers, each STAGES flops deep.
module cpd_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 3
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain <= '0;
    end else begin
      chain <= {chain[STAGES-2:0], d};
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/cpd_rst_sync.sv
// Reset synchronizer: asynchronous assertion from arst_n; the d input is
// sampled into the chain, so a low d asserts and a high d releases after
// STAGES edges.
module cpd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain <= '0;
    end else begin
      chain <= {chain[STAGES-2:0], d};
    end
  end

  assign rst_n_o = chain[STAGES-1];

endmodule

// File: rtl/cpd_fsm.sv
// Shutdown phase machine: strictly ordered, one phase per satisfied condition.
module cpd_fsm
  import cpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush_s,
  input  logic       done_s,
  input  logic       wfi_s,
  input  logic       cohx_s,
  input  logic       q_hold,
  output cpd_phase_e phase
);

  cpd_phase_e phase_nxt;

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_IDLE:   if (flush_s)            phase_nxt = PH_FLUSH;
      PH_FLUSH:  if (done_s)             phase_nxt = PH_WFI;
      PH_WFI:    if (wfi_s)              phase_nxt = PH_COHX;
      PH_COHX:   if (cohx_s && !q_hold)  phase_nxt = PH_OFFREQ;
      PH_OFFREQ:                         phase_nxt = PH_OFFREQ;
      default:                           phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else begin
      phase <= phase_nxt;
    end
  end

endmodule

// File: rtl/core_pwrdn_seq.sv
module core_pwrdn_seq
  import cpd_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 3,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_rst_n,
  input  logic flush_req,
  input  logic flush_done,
  input  logic wfi_halt,
  input  logic coh_req,
  input  logic coh_ack,
  input  logic q_active,
  input  logic q_accept_n,
  output logic off_ready,
  output logic pd_clk_gate
);

  logic                  sys_rst_n;
  logic                  blk_rst_n;
  logic [CPD_NUM_HS-1:0] hs_raw;
  logic [CPD_NUM_HS-1:0] sync_q;
  logic                  q_hold;
  logic                  gate_nxt;
  cpd_phase_e            phase;

  // System-only reset domain, used by the clock-gate flag.
  cpd_rst_sync #(.STAGES(RST_STAGES)) i_sys_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .d       (1'b1),
    .rst_n_o (sys_rst_n)
  );

  // Combined reset: system reset asynchronously, software reset through the chain.
  cpd_rst_sync #(.STAGES(RST_STAGES)) i_blk_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .d       (sw_rst_n),
    .rst_n_o (blk_rst_n)
  );

  always_comb begin
    hs_raw               = '0;
    hs_raw[CPD_HS_FLUSH] = flush_req;
    hs_raw[CPD_HS_DONE]  = flush_done;
    hs_raw[CPD_HS_WFI]   = wfi_halt;
    hs_raw[CPD_HS_COHX]  = ~coh_req & ~coh_ack;
  end

  cpd_sync #(.WIDTH(CPD_NUM_HS), .STAGES(SYNC_STAGES)) i_hs_sync (
    .clk    (clk),
    .arst_n (blk_rst_n),
    .d      (hs_raw),
    .q      (sync_q)
  );

  assign q_hold = q_active & q_accept_n;

  cpd_fsm i_fsm (
    .clk     (clk),
    .rst_n   (blk_rst_n),
    .flush_s (sync_q[CPD_HS_FLUSH]),
    .done_s  (sync_q[CPD_HS_DONE]),
    .wfi_s   (sync_q[CPD_HS_WFI]),
    .cohx_s  (sync_q[CPD_HS_COHX]),
    .q_hold  (q_hold),
    .phase   (phase)
  );

  assign off_ready = (phase == PH_OFFREQ);
  assign gate_nxt  = ~sw_rst_n & (phase == PH_OFFREQ);

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      pd_clk_gate <= 1'b0;
    end else begin
      pd_clk_gate <= gate_nxt;
    end
  end

endmodule

// File: rtl/cpd_checker.sv
module cpd_checker
  import cpd_pkg::*;
(
  input logic                  clk,
  input logic                  sys_rst_n,
  input logic                  blk_rst_n,
  input logic                  sw_rst_n,
  input cpd_phase_e            phase,
  input logic [CPD_NUM_HS-1:0] sync_q,
  input logic                  q_hold,
  input logic                  off_ready,
  input logic                  pd_clk_gate
);

  // R8: while the block reset is held, the machine sits in idle
  p_reset_idle_r8: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !blk_rst_n |-> phase == PH_IDLE);

  // R2
  p_idle_wait_r2: assert property (@(posedge clk) disable iff (!blk_rst_n)
    (phase == PH_IDLE && !sync_q[CPD_HS_FLUSH]) |=> phase == PH_IDLE);

  // R3
  p_flush_wait_r3: assert property (@(posedge clk) disable iff (!blk_rst_n)
    (phase == PH_FLUSH && !sync_q[CPD_HS_DONE]) |=> phase == PH_FLUSH);

  // R4
  p_wfi_wait_r4: assert property (@(posedge clk) disable iff (!blk_rst_n)
    (phase == PH_WFI && !sync_q[CPD_HS_WFI]) |=> phase == PH_WFI);

  // R5
  p_cohx_wait_r5: assert property (@(posedge clk) disable iff (!blk_rst_n)
    (phase == PH_COHX && !sync_q[CPD_HS_COHX]) |=> phase == PH_COHX);

  // R10
  p_qhold_r10: assert property (@(posedge clk) disable iff (!blk_rst_n)
    (phase == PH_COHX && q_hold) |=> phase == PH_COHX);

  // R6: sticky until block reset
  p_off_sticky_r6: assert property (@(posedge clk) disable iff (!blk_rst_n)
    off_ready |=> off_ready);

  // R6: only reachable from the coherency-exit phase
  p_off_entry_r6: assert property (@(posedge clk) disable iff (!blk_rst_n)
    $rose(off_ready) |-> $past(phase) == PH_COHX);

  // R9
  p_gate_cause_r9: assert property (@(posedge clk) disable iff (!sys_rst_n)
    pd_clk_gate |-> !$past(sw_rst_n));

endmodule

bind core_pwrdn_seq cpd_checker i_cpd_checker (
  .clk         (clk),
  .sys_rst_n   (sys_rst_n),
  .blk_rst_n   (blk_rst_n),
  .sw_rst_n    (sw_rst_n),
  .phase       (phase),
  .sync_q      (sync_q),
  .q_hold      (q_hold),
  .off_ready   (off_ready),
  .pd_clk_gate (pd_clk_gate)
);

// File: tb/test_core_pwrdn_seq.sv
module test_core_pwrdn_seq;

  localparam int SS = 3;
  localparam int RS = 2;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n, sw_rst_n, flush_req, flush_done, wfi_halt, coh_req, coh_ack;
  logic q_active, q_accept_n;
  logic off_ready, pd_clk_gate;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit cmp_en = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  core_pwrdn_seq #(.SYNC_STAGES(SS), .RST_STAGES(RS)) i_core_pwrdn_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_rst_n    (sw_rst_n),
    .flush_req   (flush_req),
    .flush_done  (flush_done),
    .wfi_halt    (wfi_halt),
    .coh_req     (coh_req),
    .coh_ack     (coh_ack),
    .q_active    (q_active),
    .q_accept_n  (q_accept_n),
    .off_ready   (off_ready),
    .pd_clk_gate (pd_clk_gate)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  // phases: 0 idle, 1 flush, 2 wfi, 3 coherency exit, 4 off request
  bit m_sys[$];
  bit m_blk[$];
  bit m_hs[4][$];
  int m_ph;
  bit m_pd;

  task automatic model_clear_hs();
    for (int j = 0; j < 4; j++) begin
      m_hs[j].delete();
      for (int k = 0; k < SS; k++) m_hs[j].push_back(1'b0);
    end
  endtask

  task automatic model_reset();
    m_sys.delete(); m_blk.delete();
    for (int k = 0; k < RS; k++) begin
      m_sys.push_back(1'b0);
      m_blk.push_back(1'b0);
    end
    model_clear_hs();
    m_ph = 0;
    m_pd = 1'b0;
  endtask

  initial model_reset();

  always @(posedge clk) begin : ref_model
    bit old_blk, old_sys, new_blk, new_sys, npd;
    bit hs_in[4];
    int nph;
    if (!rst_n) begin
      model_reset();
    end else begin
      old_blk = m_blk[0];
      old_sys = m_sys[0];
      nph = m_ph;
      case (m_ph)
        0: if (m_hs[0][0]) nph = 1;
        1: if (m_hs[1][0]) nph = 2;
        2: if (m_hs[2][0]) nph = 3;
        3: if (m_hs[3][0] && !(q_active && q_accept_n)) nph = 4;
        default: nph = 4;
      endcase
      npd = !sw_rst_n && (m_ph == 4);
      hs_in[0] = flush_req;
      hs_in[1] = flush_done;
      hs_in[2] = wfi_halt;
      hs_in[3] = !coh_req && !coh_ack;
      if (old_blk) begin
        for (int j = 0; j < 4; j++) begin
          void'(m_hs[j].pop_front());
          m_hs[j].push_back(hs_in[j]);
        end
        m_ph = nph;
      end
      if (old_sys) m_pd = npd;
      void'(m_sys.pop_front()); m_sys.push_back(1'b1);
      void'(m_blk.pop_front()); m_blk.push_back(sw_rst_n);
      new_blk = m_blk[0];
      new_sys = m_sys[0];
      if (!new_blk) begin
        model_clear_hs();
        m_ph = 0;
      end
      if (!new_sys) m_pd = 1'b0;
    end
  end

  // per-cycle comparison against the model (R6, R9)
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(off_ready, (m_ph == 4), "R6 per-cycle off_ready");
      chk(pd_clk_gate, m_pd, "R9 per-cycle pd_clk_gate");
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !finished) begin
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_hs_inputs();
    flush_req = 0; flush_done = 0; wfi_halt = 0; coh_req = 0; coh_ack = 0;
    q_active = 0; q_accept_n = 0;
  endtask

  task automatic sw_reset_cycle();
    clear_hs_inputs();
    sw_rst_n = 0;
    step(4);
    sw_rst_n = 1;
    step(4);
  endtask

  initial begin
    rst_n = 0; sw_rst_n = 1;
    clear_hs_inputs();
    step(3);
    rst_n = 1;
    cmp_en = 1'b1;
    step(4);
    chk(off_ready, 1'b0, "R1 off_ready after reset");
    chk(pd_clk_gate, 1'b0, "R1 pd_clk_gate after reset");

    // R2/R7: later conditions already true, then flush request
    flush_done = 1; wfi_halt = 1;
    step(5);
    flush_req = 1;
    step(SS + 3);
    chk(off_ready, 1'b0, "R7 off_ready one edge early");
    step(1);
    chk(off_ready, 1'b1, "R2 off_ready at SYNC_STAGES+4");

    // R8/R9: software reset while ready for power off
    sw_rst_n = 0;
    step(1);
    chk(pd_clk_gate, 1'b1, "R9 gate raised on first edge");
    chk(off_ready, 1'b1, "R8 still ready before reset takes effect");
    step(1);
    chk(pd_clk_gate, 1'b1, "R9 gate second edge");
    chk(off_ready, 1'b0, "R8 reset forces idle");
    step(1);
    chk(pd_clk_gate, 1'b0, "R9 gate drops once idle");
    clear_hs_inputs();
    step(3);
    sw_rst_n = 1;
    step(10);
    chk(off_ready, 1'b0, "R6 stays idle after software reset release");

    // R3: single-cycle flush pulse; later conditions early must not skip flush
    flush_req = 1;
    step(1);
    flush_req = 0;
    wfi_halt = 1;
    step(12);
    chk(off_ready, 1'b0, "R3 waiting for flush_done");
    flush_done = 1;
    step(SS + 2);
    chk(off_ready, 1'b0, "R3 one edge before off");
    step(1);
    chk(off_ready, 1'b1, "R3 off after flush_done");
    sw_reset_cycle();

    // R4: wait for WFI
    flush_req = 1; flush_done = 1;
    step(12);
    chk(off_ready, 1'b0, "R4 waiting for wfi_halt");
    wfi_halt = 1;
    step(SS + 1);
    chk(off_ready, 1'b0, "R4 one edge before off");
    step(1);
    chk(off_ready, 1'b1, "R4 off after wfi_halt");
    sw_reset_cycle();

    // R5: coherency pair must both be low
    coh_req = 1;
    flush_req = 1; flush_done = 1; wfi_halt = 1;
    step(15);
    chk(off_ready, 1'b0, "R5 coh_req high blocks");
    coh_req = 0; coh_ack = 1;
    step(10);
    chk(off_ready, 1'b0, "R5 coh_ack high blocks");
    coh_ack = 0;
    step(SS);
    chk(off_ready, 1'b0, "R5 one edge before off");
    step(1);
    chk(off_ready, 1'b1, "R5 off after both low");
    sw_reset_cycle();

    // R10: Q-channel in idle has no effect
    q_active = 1; q_accept_n = 1;
    step(10);
    chk(off_ready, 1'b0, "R10 Q pair in idle does not start");
    // R10: Q hold in coherency-exit phase
    coh_req = 1;
    flush_req = 1; flush_done = 1; wfi_halt = 1;
    step(15);
    coh_req = 0;
    step(10);
    chk(off_ready, 1'b0, "R10 held by Q pair");
    q_accept_n = 0;
    step(1);
    chk(off_ready, 1'b1, "R10 released when accept low");
    sw_reset_cycle();

    // R10: q_active alone does not hold
    q_active = 1; q_accept_n = 0;
    flush_req = 1; flush_done = 1; wfi_halt = 1;
    step(SS + 4);
    chk(off_ready, 1'b1, "R10 q_active alone no hold");
    sw_reset_cycle();

    // R9: software reset in idle never raises the gate
    sw_rst_n = 0;
    step(1);
    chk(pd_clk_gate, 1'b0, "R9 no gate from idle edge 1");
    step(2);
    chk(pd_clk_gate, 1'b0, "R9 no gate from idle edge 3");
    sw_rst_n = 1;
    step(5);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule